// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block holds sixteen hardware breakpoints and checks each retiring instruction against all of them in parallel. Every breakpoint has a control word, a value word and two extension words: one holds a virtual-machine identifier and the other holds a second, hypervisor-level context identifier. A breakpoint compares either the instruction address or the running context against its programmed value. An address breakpoint can be linked to a context breakpoint, so that it fires only inside one chosen context.

Each cycle the block takes the retiring instruction's address, its width (16 or 32 bits), the guest context ID, the hypervisor context ID, the VMID and a few execution-level qualifiers. One cycle later it presents a per-breakpoint hit vector and the OR of that vector. A plain write port loads the configuration words.

Top module: `bkpt_match_bank`

## Requirements
- R1: After reset, every breakpoint is disabled, and `bp_hit` and `any_hit` are zero.
- R2: A breakpoint whose control bit 0 is 0 never hits, whatever its other fields hold.
- R3: Address-match breakpoints (control[23:21]=000) compare the value word with the instruction address, ignoring bits [1:0]. The byte-lane field control[8:5] then picks the slot: 0011 matches a 16-bit instruction at the base, 1100 matches a 16-bit instruction at base+2, and 1111 matches a 32-bit instruction at the base.
- R4: In the address-match and mismatch types, lane codes other than 0011, 1100, 1111 (and 0000 for mismatch) never hit.
- R5: Mismatch breakpoints (control[23:21]=010) hit on every instruction except the one that the same lane code would match. Lane code 0000 hits on every instruction.
- R6: Context breakpoints of type 001 compare the value word with a target context. The target is the hypervisor context ID when `host_mode` is set and either `at_hyp` is set or both `at_user` and `trap_gen` are set. Otherwise the target is the guest context ID.
- R7: The other context types compare as follows: 011 checks the value word against the guest context ID. 100 checks the VMID extension against `cur_vmid`. 101 checks both the VMID and the guest context. 110 checks the second-context extension against the hypervisor context ID. 111 checks the guest context and the hypervisor context together.
- R8: When control bit 20 is set, an address breakpoint hits only if breakpoint control[19:16] is an enabled, linked context breakpoint whose comparison is true. In unlinked address breakpoints, the link field has no effect.
- R9: A context breakpoint with control bit 20 set never hits by itself.
- R10: The hits for the instruction sampled at a clock edge appear right after that edge. When `ins_valid` is low, the next hit vector is zero, and `any_hit` always equals the OR of `bp_hit`.
- R11: When `wr_en` is set, `wr_data` is written to breakpoint `wr_idx`. `wr_sel` picks the word: 0 is control, 1 is value, 2 is the VMID extension (low bits), and 3 is the second-context extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 4 | Breakpoint index written |
| wr_sel | input | 2 | Word select: control, value, VMID, second context |
| wr_data | input | 32 | Write data |
| ins_valid | input | 1 | An instruction retires this cycle |
| ins_addr | input | 32 | Instruction address |
| ins_wide | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| cur_cid | input | 32 | Guest context ID |
| hyp_cid | input | 32 | Hypervisor context ID |
| cur_vmid | input | 8 | Current VMID |
| host_mode | input | 1 | Host-mode qualifier for context target selection |
| at_hyp | input | 1 | Executing at the hypervisor level |
| at_user | input | 1 | Executing at user level |
| trap_gen | input | 1 | Trap-general qualifier |
| bp_hit | output | 16 | Registered per-breakpoint hit vector |
| any_hit | output | 1 | OR of the hit vector |

## Verification
The hardest case to reach is a linked address hit. It needs two breakpoints programmed in a consistent way: the address breakpoint must name, as its link target, a breakpoint that is an enabled, linked context breakpoint. That context breakpoint must also match the context on the inputs in the same cycle as the address matches. Random configurations almost never line this up. The stimulus therefore builds such pairs on purpose, then breaks one condition at a time (wrong context, wrong link index, target not marked as linked). It also draws random addresses and context values from small pools, so that matches and near-misses stay frequent.

// File: rtl/bkpt_match_bank.sv
module bkpt_match_bank #(
  parameter int NUM_BP = 16,
  parameter int AW     = 32,
  parameter int CW     = 32,
  parameter int VW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              ins_valid,
  input  logic [AW-1:0]     ins_addr,
  input  logic              ins_wide,
  input  logic [CW-1:0]     cur_cid,
  input  logic [CW-1:0]     hyp_cid,
  input  logic [VW-1:0]     cur_vmid,
  input  logic              host_mode,
  input  logic              at_hyp,
  input  logic              at_user,
  input  logic              trap_gen,
  output logic [NUM_BP-1:0] bp_hit,
  output logic              any_hit
);

  logic [31:0]   ctrl_q [NUM_BP];
  logic [AW-1:0] val_q  [NUM_BP];
  logic [VW-1:0] vm_q   [NUM_BP];
  logic [CW-1:0] cid2_q [NUM_BP];

  logic [NUM_BP-1:0] ctx_ok, addr_ok, is_addr, linked, hit_d;
  logic [3:0]        lnk_idx [NUM_BP];

  wire use_hyp = host_mode && (at_hyp || (at_user && trap_gen));
  wire [CW-1:0] cid_tgt = use_hyp ? hyp_cid : cur_cid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BP; i++) begin
        ctrl_q[i] <= '0;
        val_q[i]  <= '0;
        vm_q[i]   <= '0;
        cid2_q[i] <= '0;
      end
    end else if (wr_en && (32'(wr_idx) < NUM_BP)) begin
      case (wr_sel)
        2'd0: ctrl_q[wr_idx] <= wr_data;
        2'd1: val_q[wr_idx]  <= wr_data[AW-1:0];
        2'd2: vm_q[wr_idx]   <= wr_data[VW-1:0];
        default: cid2_q[wr_idx] <= wr_data[CW-1:0];
      endcase
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    wire       en   = ctrl_q[g][0];
    wire [2:0] kind = ctrl_q[g][23:21];
    wire [3:0] bas  = ctrl_q[g][8:5];
    wire       a_eq = val_q[g][AW-1:2] == ins_addr[AW-1:2];
    logic lane_ok, lane_legal;

    always_comb begin
      lane_legal = 1'b1;
      case (bas)
        4'b0011: lane_ok = !ins_wide && !ins_addr[1];
        4'b1100: lane_ok = !ins_wide &&  ins_addr[1];
        4'b1111: lane_ok =  ins_wide && !ins_addr[1];
        default: begin lane_ok = 1'b0; lane_legal = 1'b0; end
      endcase
    end

    wire slot = a_eq && lane_ok;

    always_comb begin
      case (kind)
        3'b001:  ctx_ok[g] = val_q[g] == cid_tgt;
        3'b011:  ctx_ok[g] = val_q[g] == cur_cid;
        3'b100:  ctx_ok[g] = vm_q[g] == cur_vmid;
        3'b101:  ctx_ok[g] = (vm_q[g] == cur_vmid) && (val_q[g] == cur_cid);
        3'b110:  ctx_ok[g] = cid2_q[g] == hyp_cid;
        3'b111:  ctx_ok[g] = (val_q[g] == cur_cid) && (cid2_q[g] == hyp_cid);
        default: ctx_ok[g] = 1'b0;
      endcase
      ctx_ok[g] = ctx_ok[g] && en;
    end

    assign is_addr[g] = (kind == 3'b000) || (kind == 3'b010);
    assign addr_ok[g] = en && ((kind == 3'b000) ? slot :
                               (bas == 4'b0000) ? 1'b1 : (lane_legal && !slot));
    assign linked[g]  = ctrl_q[g][20];
    assign lnk_idx[g] = ctrl_q[g][19:16];

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[g][0] |=> !bp_hit[g]);  // R2
    AST_LINKED_CTX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !is_addr[g] && linked[g]) |=> !bp_hit[g]);  // R9
    AST_MISMATCH_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ins_valid && ctrl_q[g][23:20] == 4'b0100 && bas == 4'b0000) |=> bp_hit[g]);  // R5
  end

  always_comb begin
    for (int i = 0; i < NUM_BP; i++) begin
      logic lk;
      lk = 1'b0;
      for (int j = 0; j < NUM_BP; j++)
        if (32'(lnk_idx[i]) == j) lk = ctx_ok[j] && linked[j] && !is_addr[j];
      if (is_addr[i]) hit_d[i] = ins_valid && addr_ok[i] && (!linked[i] || lk);
      else            hit_d[i] = ins_valid && ctx_ok[i] && !linked[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_hit  <= '0;
      any_hit <= 1'b0;
    end else begin
      bp_hit  <= hit_d;
      any_hit <= |hit_d;
    end
  end

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> (bp_hit == '0));  // R10
  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (|bp_hit));  // R10

endmodule

// File: tb/test_bkpt_match_bank.sv
module test_bkpt_match_bank;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic ins_valid = 0, ins_wide = 0;
  logic [31:0] ins_addr = 0, cur_cid = 0, hyp_cid = 0;
  logic [7:0] cur_vmid = 0;
  logic host_mode = 0, at_hyp = 0, at_user = 0, trap_gen = 0;
  logic [15:0] bp_hit;
  logic any_hit;

  int checks = 0, errors = 0;
  logic [31:0] s_ctrl [16], s_val [16], s_cid2 [16];
  logic [7:0]  s_vm [16];

  always #4 clk = ~clk;

  bkpt_match_bank i_bkpt_match_bank (.*);

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic ctx_match(int j);
    logic [2:0] k = s_ctrl[j][23:21];
    logic [31:0] tgt = (host_mode && (at_hyp || (at_user && trap_gen))) ? hyp_cid : cur_cid;
    if (!s_ctrl[j][0]) return 0;
    case (k)
      3'b001: return s_val[j] == tgt;
      3'b011: return s_val[j] == cur_cid;
      3'b100: return s_vm[j] == cur_vmid;
      3'b101: return s_vm[j] == cur_vmid && s_val[j] == cur_cid;
      3'b110: return s_cid2[j] == hyp_cid;
      3'b111: return s_val[j] == cur_cid && s_cid2[j] == hyp_cid;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] model();
    logic [15:0] e = 0;
    for (int i = 0; i < 16; i++) begin
      logic [2:0] k = s_ctrl[i][23:21];
      logic [3:0] b = s_ctrl[i][8:5];
      logic slot, legal, cond, lk;
      int t = s_ctrl[i][19:16];
      legal = (b == 4'b0011) || (b == 4'b1100) || (b == 4'b1111);
      slot = (s_val[i][31:2] == ins_addr[31:2]) &&
             ((b == 4'b0011 && !ins_wide && !ins_addr[1]) ||
              (b == 4'b1100 && !ins_wide && ins_addr[1]) ||
              (b == 4'b1111 && ins_wide && !ins_addr[1]));
      if (!ins_valid || !s_ctrl[i][0]) continue;
      if (k == 3'b000 || k == 3'b010) begin
        cond = (k == 3'b000) ? slot : (b == 0 ? 1'b1 : legal && !slot);
        lk = ctx_match(t) && s_ctrl[t][20] && s_ctrl[t][23:21] != 3'b000 && s_ctrl[t][23:21] != 3'b010;
        e[i] = cond && (!s_ctrl[i][20] || lk);
      end else
        e[i] = ctx_match(i) && !s_ctrl[i][20];
    end
    return e;
  endfunction

  task automatic wr(int idx, int sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_sel = 2'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (sel)
      0: s_ctrl[idx] = d;
      1: s_val[idx] = d;
      2: s_vm[idx] = d[7:0];
      default: s_cid2[idx] = d;
    endcase
  endtask

  function automatic logic [31:0] mk(int ty, int lnk, int bas, bit en);
    return (32'(ty) << 20) | (32'(lnk) << 16) | (32'(bas) << 5) | 32'(en);
  endfunction

  task automatic step(string tag, logic v, logic [31:0] a, logic w);
    logic [15:0] e;
    ins_valid = v; ins_addr = a; ins_wide = w;
    e = model();
    @(negedge clk);
    checks++;
    if (bp_hit !== e || any_hit !== (|e)) begin
      errors++;
      $display("FAIL %s hit=%h any=%b expected hit=%h any=%b", tag, bp_hit, any_hit, e, |e);
    end
    ins_valid = 0;
  endtask

  task automatic expect_bit(string tag, int i, logic exp);
    checks++;
    if (bp_hit[i] !== exp) begin
      errors++;
      $display("FAIL %s bp%0d=%b expected %b", tag, i, bp_hit[i], exp);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin s_ctrl[i] = 0; s_val[i] = 0; s_vm[i] = 0; s_cid2[i] = 0; end
    #20; @(negedge clk); rst_n = 1;
    checks++;
    if (bp_hit !== 0 || any_hit !== 0) begin errors++; $display("FAIL R1 hit=%h any=%b expected 0 0", bp_hit, any_hit); end

    // R3 R11 lanes and low-bit masking
    wr(0, 1, 32'h1001);
    wr(0, 0, mk(4'b0000, 0, 4'b0011, 1));
    step("R3", 1, 32'h1000, 0); expect_bit("R3", 0, 1);
    step("R3", 1, 32'h1002, 0); expect_bit("R3", 0, 0);
    wr(0, 0, mk(4'b0000, 0, 4'b1100, 1));
    step("R3", 1, 32'h1002, 0); expect_bit("R3", 0, 1);
    wr(0, 0, mk(4'b0000, 0, 4'b1111, 1));
    step("R3", 1, 32'h1000, 1); expect_bit("R3", 0, 1);
    step("R10", 0, 32'h1000, 1); expect_bit("R10", 0, 0);
    wr(0, 0, mk(4'b0000, 0, 4'b0101, 1));
    step("R4", 1, 32'h1000, 1); expect_bit("R4", 0, 0);
    wr(0, 0, mk(4'b0000, 0, 4'b1111, 0));
    step("R2", 1, 32'h1000, 1); expect_bit("R2", 0, 0);

    // R5 mismatch
    wr(1, 1, 32'h2000);
    wr(1, 0, mk(4'b0100, 0, 4'b1111, 1));
    step("R5", 1, 32'h2000, 1); expect_bit("R5", 1, 0);
    step("R5", 1, 32'h3000, 1); expect_bit("R5", 1, 1);
    wr(1, 0, mk(4'b0100, 0, 4'b0000, 1));
    step("R5", 1, 32'h2000, 1); expect_bit("R5", 1, 1);
    wr(1, 0, mk(4'b0100, 0, 4'b0110, 1));
    step("R4", 1, 32'h3000, 1); expect_bit("R4", 1, 0);
    wr(1, 0, 0);

    // R6 context target switching
    wr(2, 1, 32'hAA);
    wr(2, 0, mk(4'b0010, 0, 4'b1111, 1));
    cur_cid = 32'hAA; hyp_cid = 32'hBB;
    step("R6", 1, 0, 0); expect_bit("R6", 2, 1);
    host_mode = 1; at_hyp = 1;
    step("R6", 1, 0, 0); expect_bit("R6", 2, 0);
    at_hyp = 0; at_user = 1; trap_gen = 1; cur_cid = 0; hyp_cid = 32'hAA;
    step("R6", 1, 0, 0); expect_bit("R6", 2, 1);
    trap_gen = 0;
    step("R6", 1, 0, 0); expect_bit("R6", 2, 0);
    host_mode = 0; at_user = 0; wr(2, 0, 0);

    // R8 R9 linking
    wr(3, 1, 32'h55);
    wr(3, 0, mk(4'b0111, 0, 4'b1111, 1));
    wr(4, 1, 32'h4000);
    wr(4, 0, mk(4'b0001, 3, 4'b1111, 1));
    cur_cid = 32'h55;
    step("R8", 1, 32'h4000, 1); expect_bit("R8", 4, 1); expect_bit("R9", 3, 0);
    cur_cid = 32'h56;
    step("R8", 1, 32'h4000, 1); expect_bit("R8", 4, 0);
    cur_cid = 32'h55;
    wr(4, 0, mk(4'b0001, 5, 4'b1111, 1));
    step("R8", 1, 32'h4000, 1); expect_bit("R8", 4, 0);
    wr(3, 0, mk(4'b0110, 0, 4'b1111, 1));
    wr(4, 0, mk(4'b0001, 3, 4'b1111, 1));
    step("R8", 1, 32'h4000, 1); expect_bit("R8", 4, 0); expect_bit("R8", 3, 1);
    wr(4, 0, mk(4'b0000, 9, 4'b1111, 1));
    step("R8", 1, 32'h4000, 1); expect_bit("R8", 4, 1);
    wr(3, 0, 0); wr(4, 0, 0);

    // R7 VMID and full context
    wr(5, 2, 32'h7); wr(5, 3, 32'hC2); wr(5, 1, 32'hC1);
    cur_vmid = 7; cur_cid = 32'hC1; hyp_cid = 32'hC2;
    for (int t = 8; t < 16; t += 2) begin
      wr(5, 0, mk(t, 0, 4'b1111, 1));
      step("R7", 1, 0, 0); expect_bit("R7", 5, 1);
    end
    cur_vmid = 6;
    wr(5, 0, mk(4'b1000, 0, 4'b1111, 1));
    step("R7", 1, 0, 0); expect_bit("R7", 5, 0);
    wr(5, 0, 0);

    // random mix, all requirements against the model
    for (int it = 0; it < 600; it++) begin
      if (it % 12 == 0) begin
        int idx = $urandom % 16;
        int bsel = $urandom % 5;
        int bas = (bsel == 0) ? 0 : (bsel == 1) ? 3 : (bsel == 2) ? 12 : (bsel == 3) ? 15 : ($urandom % 16);
        wr(idx, 1, ($urandom % 2) ? (32'h1000 + 32'($urandom % 2) * 4) : 32'($urandom % 3));
        wr(idx, 2, 32'($urandom % 2 + 3));
        wr(idx, 3, 32'($urandom % 3));
        wr(idx, 0, mk($urandom % 16, $urandom % 16, bas, ($urandom % 4) != 0));
      end
      cur_cid = 32'($urandom % 3); hyp_cid = 32'($urandom % 3);
      cur_vmid = 8'($urandom % 2 + 3);
      {host_mode, at_hyp, at_user, trap_gen} = 4'($urandom);
      step("R10", ($urandom % 8) != 0, 32'h1000 + 32'($urandom % 5) * 2, $urandom % 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule